// File: doc/BRIEF.md
# Streaming Binary Morphology Row Pipeline

This block takes a camera row stream, one digitized pixel per valid cycle, and turns it into a binary image. It keeps only the upper bits of each sample, compares them with a threshold that can change at run time, and then applies a 3×3 binary morphology operation over the 8-neighbourhood. The operation is erosion, dilation, erosion-based edge detection, or a plain copy of the binary pixel.

Rows arrive one after another. Two one-bit line buffers hold the two previous binary rows, and a two-column window slides along the row being received. The output for a row is produced while the following row streams in. When the last row of a frame is complete, the block flushes the final output row by itself, padding the missing bottom row.

Top module: `morph_row_pipe`

## Requirements
- R1: A pixel is 1 exactly when the sample's upper 8 bits (in_sample[10:3]), read as unsigned, are greater than or equal to thresh. The lower 3 bits have no effect.
- R2: With op_sel = 2'b00, each output pixel is the AND of the nine binary pixels of its 3×3 window (erosion).
- R3: With op_sel = 2'b01, each output pixel is the OR of the nine pixels of its 3×3 window (dilation).
- R4: With op_sel = 2'b10, each output pixel is the centre pixel AND NOT the R2 erosion result (inner edge).
- R5: With op_sel = 2'b11, each output pixel equals the binary centre pixel.
- R6: Positions outside the image count as 1 for erosion and edge, and as 0 for dilation.
- R7: Each frame gives exactly IMG_W×IMG_H outputs in row-major order. out_sor is high only on column 0. out_eof is high only on the final pixel of the frame.
- R8: Output (r,c) with c < IMG_W-1 appears in the cycle after input (r+1,c+1) is accepted. Output (r,IMG_W-1) appears after input (r+2,0) is accepted. The last row leaves in IMG_W+1 self-timed cycles after the final sample, with out_eof in the last of them. Apart from the flush, no output appears without an accepted sample.
- R9: Samples presented while the flush runs are ignored and do not count toward the next frame.
- R10: A sample with in_sor high is taken as column 0, whatever the column count was before.
- R11: While reset is asserted, and in the cycle after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sor | input | 1 | The presented sample is column 0 of a row |
| in_sample | input | 11 | Digitized pixel value |
| thresh | input | 8 | Binarization threshold |
| op_sel | input | 2 | Operation: 00 erode, 01 dilate, 10 edge, 11 pass |
| out_valid | output | 1 | An output pixel is present |
| out_sor | output | 1 | The output pixel is column 0 |
| out_eof | output | 1 | The output pixel is the last of the frame |
| out_pix | output | 1 | Binary output pixel |

## Verification
The assertions check the framing on every cycle:
- flags appear only together with a valid output;
- outputs appear only after an accepted sample or during the flush;
- every flush cycle produces a pixel;
- out_eof coincides with the end of the flush;
- the output stays quiet across reset.

The pixel values need full frames, so only the bench scenarios can show them. These cover each operation against an independent neighbourhood model, border padding, threshold equality with varying low bits, and exact latency. They also cover samples ignored during the flush and column resynchronization by in_sor.

// File: rtl/morph_pkg.sv
package morph_pkg;

    typedef enum logic [1:0] {
        OP_ERODE  = 2'b00,
        OP_DILATE = 2'b01,
        OP_EDGE   = 2'b10,
        OP_PASS   = 2'b11
    } op_t;

    // one column of the 3x3 window: row above, centre row, row below
    typedef struct packed {
        logic top;
        logic mid;
        logic bot;
    } col_t;

endpackage

// File: rtl/morph_binarize.sv
module morph_binarize #(
    parameter int KEEP_W = 8
) (
    input  logic [KEEP_W-1:0] level,
    input  logic [KEEP_W-1:0] thresh,
    output logic              pix
);
    logic [KEEP_W:0] diff;

    always_comb begin
        diff = {1'b0, level} - {1'b0, thresh};
        pix  = ~diff[KEEP_W];   // non-negative difference -> 1
    end
endmodule

// File: rtl/morph_linebuf.sv
module morph_linebuf #(
    parameter int DEPTH = 128,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          rd_new,
    output logic          rd_old
);
    logic [DEPTH-1:0] mem_new;
    logic [DEPTH-1:0] mem_old;

    assign rd_new = mem_new[addr];
    assign rd_old = mem_old[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_old[addr] <= mem_new[addr];
            mem_new[addr] <= din;
        end
    end
endmodule

// File: rtl/morph_kernel.sv
module morph_kernel
    import morph_pkg::*;
(
    input  col_t left,
    input  col_t ctr,
    input  col_t right,
    input  op_t  op,
    output logic pix
);
    logic all1, any1;

    always_comb begin
        all1 = &{left, ctr, right};
        any1 = |{left, ctr, right};
        unique case (op)
            OP_ERODE:  pix = all1;
            OP_DILATE: pix = any1;
            OP_EDGE:   pix = ctr.mid & ~all1;
            default:   pix = ctr.mid;
        endcase
    end
endmodule

// File: rtl/morph_row_pipe.sv
module morph_row_pipe
    import morph_pkg::*;
#(
    parameter int IMG_W    = 128,
    parameter int IMG_H    = 128,
    parameter int SAMPLE_W = 11,
    parameter int KEEP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sor,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [KEEP_W-1:0]   thresh,
    input  logic [1:0]          op_sel,
    output logic                out_valid,
    output logic                out_sor,
    output logic                out_eof,
    output logic                out_pix
);
    localparam int COL_W = $clog2(IMG_W + 1);
    localparam int ROW_W = $clog2(IMG_H + 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             flush;
        col_t             win1;   // centre column
        col_t             win2;   // column left of centre
        logic             ov;
        logic             osor;
        logic             oeof;
        logic             opix;
    } state_t;

    state_t s_q, s_d;

    op_t              op;
    logic             bin_pix, lb_new, lb_old, lb_we, kpix;
    logic             ev, at_end, tail, emit, pad, flushing;
    logic [COL_W-1:0] cidx, lb_addr;
    logic [ROW_W-1:0] r_eff;
    col_t             padcol, newcol, k_left, k_right;

    assign op       = op_t'(op_sel);
    assign flushing = s_q.flush;

    morph_binarize #(.KEEP_W(KEEP_W)) u_bin (
        .level  (in_sample[SAMPLE_W-1 -: KEEP_W]),
        .thresh (thresh),
        .pix    (bin_pix)
    );

    morph_linebuf #(.DEPTH(IMG_W), .AW(COL_W)) u_lb (
        .clk    (clk),
        .we     (lb_we),
        .addr   (lb_addr),
        .din    (bin_pix),
        .rd_new (lb_new),
        .rd_old (lb_old)
    );

    morph_kernel u_kern (
        .left  (k_left),
        .ctr   (s_q.win1),
        .right (k_right),
        .op    (op),
        .pix   (kpix)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ov    = 1'b0;
        s_d.osor  = 1'b0;
        s_d.oeof  = 1'b0;

        ev      = s_q.flush | in_valid;
        cidx    = (!s_q.flush && in_sor) ? '0 : s_q.col;
        r_eff   = s_q.flush ? ROW_W'(IMG_H) : s_q.row;
        at_end  = (cidx == COL_W'(IMG_W));
        tail    = (cidx == '0);
        lb_addr = at_end ? '0 : cidx;
        lb_we   = in_valid & ~s_q.flush;

        pad        = (op != OP_DILATE);
        padcol     = '{top: pad, mid: pad, bot: pad};
        newcol.top = (at_end || r_eff == ROW_W'(1)) ? pad : lb_old;
        newcol.mid = at_end ? pad : lb_new;
        newcol.bot = s_q.flush ? pad : bin_pix;

        // column 0 of a row completes the previous output row's last pixel
        k_left  = (cidx == COL_W'(1)) ? padcol : s_q.win2;
        k_right = tail ? padcol : newcol;
        emit    = tail ? (r_eff >= ROW_W'(2)) : (r_eff >= ROW_W'(1));

        if (ev) begin
            s_d.win2 = s_q.win1;
            s_d.win1 = newcol;
            s_d.ov   = emit;
            s_d.osor = emit && (cidx == COL_W'(1));
            s_d.oeof = emit && at_end;
            s_d.opix = kpix;
            if (s_q.flush) begin
                if (at_end) begin
                    s_d.flush = 1'b0;
                    s_d.col   = '0;
                    s_d.row   = '0;
                end else begin
                    s_d.col = cidx + COL_W'(1);
                end
            end else if (cidx == COL_W'(IMG_W - 1)) begin
                s_d.col = '0;
                if (s_q.row == ROW_W'(IMG_H - 1)) begin
                    s_d.flush = 1'b1;
                    s_d.row   = '0;
                end else begin
                    s_d.row = s_q.row + ROW_W'(1);
                end
            end else begin
                s_d.col = cidx + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_sor   = s_q.osor;
    assign out_eof   = s_q.oeof;
    assign out_pix   = s_q.opix;
endmodule

// File: rtl/morph_row_pipe_chk.sv
module morph_row_pipe_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic flushing,
    input logic out_valid,
    input logic out_sor,
    input logic out_eof
);
    p_sor_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sor |-> out_valid);

    p_eof_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid && !flushing);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flushing) |=> !out_valid);

    p_flush_emits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> out_valid);

    p_flush_end_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flushing) |-> out_eof);

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind morph_row_pipe morph_row_pipe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .flushing  (flushing),
    .out_valid (out_valid),
    .out_sor   (out_sor),
    .out_eof   (out_eof)
);

// File: tb/test_morph_row_pipe.sv
module test_morph_row_pipe;
    localparam int W = 8;
    localparam int H = 5;
    localparam int CLK_PERIOD = 10;
    localparam int NPIX = W * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sor = 1'b0;
    logic [10:0] in_sample = '0;
    logic [7:0]  thresh = '0;
    logic [1:0]  op_sel = '0;
    logic        out_valid, out_sor, out_eof, out_pix;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nout = 0;
    int samp [H][W];
    int acc  [H][W];
    bit got_pix [64];
    bit got_sor [64];
    bit got_eof [64];
    int got_cyc [64];

    morph_row_pipe #(.IMG_W(W), .IMG_H(H)) i_morph_row_pipe (
        .clk, .rst_n, .in_valid, .in_sor, .in_sample, .thresh, .op_sel,
        .out_valid, .out_sor, .out_eof, .out_pix
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (nout < 64) begin
                got_pix[nout] = out_pix;
                got_sor[nout] = out_sor;
                got_eof[nout] = out_eof;
                got_cyc[nout] = cyc;
            end
            nout = nout + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit bpix(int r, int c, int thr);
        return (samp[r][c] >> 3) >= thr;
    endfunction

    function automatic bit ref_out(int op, int r, int c, int thr);
        bit a = 1'b1;
        bit o = 1'b0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int rr = r + dr;
                int cc = c + dc;
                if (rr < 0 || rr >= H || cc < 0 || cc >= W) begin
                    o = o | 1'b0;   // R6: dilation sees 0 outside
                    a = a & 1'b1;   // R6: erosion sees 1 outside
                end else begin
                    a = a & bpix(rr, cc, thr);
                    o = o | bpix(rr, cc, thr);
                end
            end
        end
        case (op)
            0: return a;
            1: return o;
            2: return bpix(r, c, thr) & ~a;
            default: return bpix(r, c, thr);
        endcase
    endfunction

    task automatic send(input int s, input bit sor);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sor    = sor;
        in_sample = 11'(s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sor   = 1'b0;
        end
    endtask

    task automatic run_frame(input int op, input int thr, input int gap,
                             input bit noisy_flush, input bit glitch, input string tag);
        op_sel = 2'(op);
        thresh = 8'(thr);
        nout   = 0;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (glitch && r == 0 && c == 0) begin
                    send(2047, 1'b1);
                    send(0, 1'b0);
                    send(2047, 1'b0);
                end
                send(samp[r][c], c == 0);
                acc[r][c] = cyc + 1;
                if (gap > 0 && (c % gap) == gap - 1 && !(r == H-1 && c == W-1)) idle(1);
            end
        end
        if (noisy_flush) begin
            for (int i = 0; i <= W; i++) send((i * 301) % 2048, i == 0);
        end
        idle(W + 4);
        chk(nout == NPIX, "R7 output count", nout, NPIX);
        for (int i = 0; i < NPIX && i < nout; i++) begin
            int r = i / W;
            int c = i % W;
            bit e = ref_out(op, r, c, thr);
            chk(got_pix[i] == e, tag, got_pix[i], e);
            chk(got_sor[i] == (c == 0), "R7 out_sor", got_sor[i], c == 0);
            chk(got_eof[i] == (i == NPIX-1), "R7 out_eof", got_eof[i], i == NPIX-1);
        end
    endtask

    task automatic fill_mixed(input int seed);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                samp[r][c] = ((r * 37 + c * 91 + seed * 53) * 13 + ((r * c) % 5) * 400) % 2048;
    endtask

    task automatic test_reset;   // R11
        chk(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    endtask

    task automatic test_erode;   // R2, R6
        fill_mixed(1);
        run_frame(0, 100, 0, 1'b0, 1'b0, "R2/R6 erosion pixel");
    endtask

    task automatic test_dilate;  // R3, R6
        fill_mixed(2);
        run_frame(1, 160, 3, 1'b0, 1'b0, "R3/R6 dilation pixel");
    endtask

    task automatic test_edge;    // R4
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                samp[r][c] = (r >= 1 && c >= 1 && c <= 5) ? 1800 : 200;
        run_frame(2, 128, 0, 1'b0, 1'b0, "R4 edge pixel");
    endtask

    task automatic test_threshold_pass;  // R1, R5
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                samp[r][c] = ((100 + ((r + c) % 3) - 1) << 3) | ((c * 5 + r) % 8);
        run_frame(3, 100, 2, 1'b0, 1'b0, "R1/R5 threshold pass pixel");
        chk(got_pix[1] == 1'b1, "R1 equal level gives 1", got_pix[1], 1);
        chk(got_pix[0] == 1'b0, "R1 level one below gives 0", got_pix[0], 0);
    endtask

    task automatic test_latency;  // R8
        fill_mixed(3);
        run_frame(0, 90, 0, 1'b0, 1'b0, "R8 latency frame pixel");
        chk(got_cyc[0] == acc[1][1], "R8 first output cycle", got_cyc[0], acc[1][1]);
        chk(got_cyc[W-1] == acc[2][0], "R8 row tail cycle", got_cyc[W-1], acc[2][0]);
        chk(got_cyc[NPIX-1] == acc[H-1][W-1] + W + 1, "R8 flush eof cycle",
            got_cyc[NPIX-1], acc[H-1][W-1] + W + 1);
    endtask

    task automatic test_flush_ignore;  // R9
        fill_mixed(4);
        run_frame(1, 120, 0, 1'b1, 1'b0, "R9 frame with noise in flush");
        fill_mixed(5);
        run_frame(0, 110, 0, 1'b0, 1'b0, "R9 next frame after noisy flush");
    endtask

    task automatic test_resync;  // R10
        fill_mixed(6);
        run_frame(3, 130, 0, 1'b0, 1'b1, "R10 frame after in_sor resync");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        test_erode();
        test_dilate();
        test_edge();
        test_threshold_pass();
        test_latency();
        test_flush_ignore();
        test_resync();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule